// File: doc/BRIEF.md
# Zero-Turnaround Burst SRAM Core

This block is a synthesizable behavioural model of a synchronous static RAM with a flow-through read path and no idle cycles between reads and writes. On every enabled rising clock edge it decodes three chip enables, a load/advance select, a read/write select, four byte-lane write enables, a clock enable and a sleep input. Each decoded command either starts a burst at an external address, continues the current burst, deselects the device or, when the clock enable is inactive, stalls it. The 36-bit data word is split into four 9-bit lanes. The bus is modelled as separate input and output vectors with a drive-enable flag.

Read data comes straight from the array during the cycle that follows the edge that registered the address. Write data is taken on the next enabled edge. A write that follows a read therefore needs no dead cycle, and neither does a read that follows a write. Bursts are linear and four accesses long: only the two low address bits count, modulo four, so the fifth access lands on the starting address again.

The controller has three states. `ST_IDLE` means deselected, `ST_READ` means a read burst is active, and `ST_WRITE` means a write burst is active. The transitions are:
- **deselect**: any state goes to `ST_IDLE` on a load while not selected.
- **load-read**: any state goes to `ST_READ`.
- **load-write**: any state goes to `ST_WRITE`.
- **continue**: the state is kept.
- **stall**: everything holds.
- **sleep**: any state is forced to `ST_IDLE`.

Top module: `zbt_sram_core`

## Requirements
- R1: After reset the device is in `ST_IDLE`, with `dq_oe`=0 and `dq_o`=0.
- R2: A load cycle (`adv_ld`=0) on an enabled edge deselects the device when `ce1_n`=1, `ce2_n`=1 or `ce3`=0; the bus is then not driven. A continue cycle (`adv_ld`=1) while deselected keeps the device deselected, whatever the enables and `rw_n` are.
- R3: A selected load with `rw_n`=1 starts a read. In the following cycle `dq_o` equals the word at `addr` and `dq_oe`=1, provided `oe_n`=0.
- R4: A continue cycle keeps the direction set at burst start and ignores `rw_n` and the chip enables. It adds one, modulo 4, to address bits [1:0] and leaves the upper bits unchanged, so the fifth access returns to the start address.
- R5: A selected load with `rw_n`=0 starts a write. `bw_n` is sampled with each address, and `dq_i` is sampled on the next enabled edge. Lane k (`dq_i` bits [9k+8:9k]) is written only when `bw_n[k]`=0.
- R6: A write cycle with `bw_n`=4'b1111 writes nothing, and the burst address still advances on continue cycles.
- R7: A read cycle with `oe_n`=1 leaves the bus undriven. `oe_n` acts combinationally, and the burst address still advances.
- R8: The bus is never driven during a write burst, even with `oe_n`=0.
- R9: With `cke_n`=1 the edge is ignored. State and address hold, no write happens, and a read keeps driving the same data while a write stays undriven. The pending write completes on the next enabled edge with the `dq_i` of that edge.
- R10: With `zz`=1 the bus is undriven at once. Each edge in sleep performs no write and leaves the device deselected.
- R11: A read loaded on the same edge that takes a write's data returns the new data in the next cycle. A write may directly follow a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| ce1_n | input | 1 | Chip enable, active low |
| ce2_n | input | 1 | Second chip enable, active low |
| ce3 | input | 1 | Third chip enable, active high |
| adv_ld | input | 1 | 0 = load external address, 1 = continue burst |
| rw_n | input | 1 | 1 = read, 0 = write (load cycles only) |
| bw_n | input | 4 | Byte-lane write enables, active low |
| oe_n | input | 1 | Output enable, active low, asynchronous |
| cke_n | input | 1 | Clock enable, active low |
| zz | input | 1 | Sleep request, active high |
| addr | input | AW (6) | External word address |
| dq_i | input | 36 | Write data bus |
| dq_o | output | 36 | Read data bus (zero when not driven) |
| dq_oe | output | 1 | Data bus drive enable |

## Verification
The assertions check four properties on every cycle: the bus is never driven during a write burst or in sleep, a stall freezes state and address and blocks writes, a deselecting load lands in `ST_IDLE`, and a continue cycle keeps the direction and steps only the low two address bits. Array contents cannot be checked by these properties. Only the bench scenarios can show them, with a behavioural reference model compared on every clock. The scenarios cover byte-lane merging, aborted writes that leave data intact, a write stalled until its data arrives, a write dropped by sleep, and read-after-write with no gap.

// File: rtl/zbt_sram_pkg.sv
package zbt_sram_pkg;

    localparam int LANES  = 4;
    localparam int LANE_W = 9;
    localparam int WORD_W = LANES * LANE_W;
    localparam int BURST_BITS = 2;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_READ  = 2'd1,
        ST_WRITE = 2'd2
    } zbt_state_e;

    typedef enum logic [1:0] {
        CMD_DESEL   = 2'd0,
        CMD_LOAD_RD = 2'd1,
        CMD_LOAD_WR = 2'd2,
        CMD_CONT    = 2'd3
    } zbt_cmd_e;

endpackage

// File: rtl/zbt_sram_ctrl.sv
module zbt_sram_ctrl
    import zbt_sram_pkg::*;
#(
    parameter int NLANE = LANES
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cke_n,
    input  logic             zz,
    input  logic             sel,
    input  logic             adv_ld,
    input  logic             rw_n,
    input  logic [NLANE-1:0] bw_n,
    input  logic             oe_n,
    output zbt_state_e       state_q,
    output logic             load,
    output logic             inc,
    output logic             wr_en,
    output logic [NLANE-1:0] wr_mask,
    output logic             dq_oe
);

    zbt_cmd_e         cmd;
    zbt_state_e       state_n;
    logic [NLANE-1:0] mask_q;
    logic [NLANE-1:0] mask_n;
    logic             edge_en;

    // command decode
    always_comb begin
        if (adv_ld)
            cmd = CMD_CONT;
        else if (!sel)
            cmd = CMD_DESEL;
        else if (rw_n)
            cmd = CMD_LOAD_RD;
        else
            cmd = CMD_LOAD_WR;
    end

    // next state
    always_comb begin
        unique case (cmd)
            CMD_DESEL:   state_n = ST_IDLE;
            CMD_LOAD_RD: state_n = ST_READ;
            CMD_LOAD_WR: state_n = ST_WRITE;
            CMD_CONT:    state_n = state_q;
            default:     state_n = ST_IDLE;
        endcase
        mask_n = (state_n == ST_WRITE) ? ~bw_n : '0;
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            mask_q  <= '0;
        end else if (zz) begin
            state_q <= ST_IDLE;
            mask_q  <= '0;
        end else if (!cke_n) begin
            state_q <= state_n;
            mask_q  <= mask_n;
        end
    end

    // outputs
    always_comb begin
        edge_en = !cke_n && !zz;
        load    = edge_en && ((cmd == CMD_LOAD_RD) || (cmd == CMD_LOAD_WR));
        inc     = edge_en && (cmd == CMD_CONT) && (state_q != ST_IDLE);
        wr_en   = 1'b0;
        dq_oe   = 1'b0;
        unique case (state_q)
            ST_IDLE:  ;
            ST_READ:  dq_oe = !oe_n && !zz;
            ST_WRITE: wr_en = edge_en && (|mask_q);
            default:  ;
        endcase
        wr_mask = mask_q;
    end

endmodule

// File: rtl/zbt_sram_burst_addr.sv
module zbt_sram_burst_addr
    import zbt_sram_pkg::*;
#(
    parameter int AW = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic          inc,
    input  logic [AW-1:0] addr_in,
    output logic [AW-1:0] addr_q
);

    localparam int BB = BURST_BITS;

    logic [BB-1:0] low_next;

    always_comb low_next = addr_q[BB-1:0] + {{(BB-1){1'b0}}, 1'b1};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            addr_q <= '0;
        else if (load)
            addr_q <= addr_in;
        else if (inc)
            addr_q <= {addr_q[AW-1:BB], low_next};
    end

endmodule

// File: rtl/zbt_sram_array.sv
module zbt_sram_array
    import zbt_sram_pkg::*;
#(
    parameter int AW    = 6,
    parameter int NLANE = LANES,
    parameter int LW    = LANE_W
) (
    input  logic                clk,
    input  logic                we,
    input  logic [NLANE-1:0]    mask,
    input  logic [AW-1:0]       addr,
    input  logic [NLANE*LW-1:0] wdata,
    output logic [NLANE*LW-1:0] rdata
);

    localparam int DEPTH = 1 << AW;

    for (genvar k = 0; k < NLANE; k++) begin : g_lane
        logic [LW-1:0] lane_mem [DEPTH];

        always_ff @(posedge clk) begin
            if (we && mask[k])
                lane_mem[addr] <= wdata[k*LW +: LW];
        end

        assign rdata[k*LW +: LW] = lane_mem[addr];
    end

endmodule

// File: rtl/zbt_sram_core.sv
module zbt_sram_core
    import zbt_sram_pkg::*;
#(
    parameter int AW = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce1_n,
    input  logic              ce2_n,
    input  logic              ce3,
    input  logic              adv_ld,
    input  logic              rw_n,
    input  logic [LANES-1:0]  bw_n,
    input  logic              oe_n,
    input  logic              cke_n,
    input  logic              zz,
    input  logic [AW-1:0]     addr,
    input  logic [WORD_W-1:0] dq_i,
    output logic [WORD_W-1:0] dq_o,
    output logic              dq_oe
);

    zbt_state_e        state_q;
    logic              sel;
    logic              load;
    logic              inc;
    logic              wr_en;
    logic [LANES-1:0]  wr_mask;
    logic [AW-1:0]     addr_q;
    logic [WORD_W-1:0] rdata;

    assign sel = !ce1_n && !ce2_n && ce3;

    zbt_sram_ctrl #(.NLANE(LANES)) u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .cke_n   (cke_n),
        .zz      (zz),
        .sel     (sel),
        .adv_ld  (adv_ld),
        .rw_n    (rw_n),
        .bw_n    (bw_n),
        .oe_n    (oe_n),
        .state_q (state_q),
        .load    (load),
        .inc     (inc),
        .wr_en   (wr_en),
        .wr_mask (wr_mask),
        .dq_oe   (dq_oe)
    );

    zbt_sram_burst_addr #(.AW(AW)) u_addr (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (load),
        .inc     (inc),
        .addr_in (addr),
        .addr_q  (addr_q)
    );

    zbt_sram_array #(.AW(AW), .NLANE(LANES), .LW(LANE_W)) u_array (
        .clk   (clk),
        .we    (wr_en),
        .mask  (wr_mask),
        .addr  (addr_q),
        .wdata (dq_i),
        .rdata (rdata)
    );

    assign dq_o = dq_oe ? rdata : '0;

endmodule

// File: rtl/zbt_sram_checker.sv
module zbt_sram_checker
    import zbt_sram_pkg::*;
#(
    parameter int AW = 6
) (
    input logic          clk,
    input logic          rst_n,
    input logic          cke_n,
    input logic          zz,
    input logic          adv_ld,
    input logic          sel,
    input logic          dq_oe,
    input logic          wr_en,
    input zbt_state_e    state_q,
    input logic [AW-1:0] addr_q
);

    AST_WRITE_DRIVE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WRITE) |-> !dq_oe); // R8

    AST_SLEEP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        zz |-> (!dq_oe && !wr_en)); // R10

    AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (cke_n && !zz) |=> ($stable(state_q) && $stable(addr_q))); // R9

    AST_STALL_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        cke_n |-> !wr_en); // R9

    AST_DESEL_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!cke_n && !zz && !adv_ld && !sel) |=> (state_q == ST_IDLE)); // R2

    AST_BURST_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (!cke_n && !zz && adv_ld && (state_q != ST_IDLE)) |=>
        ((addr_q[AW-1:2] == $past(addr_q[AW-1:2])) &&
         (addr_q[1:0] == $past(addr_q[1:0]) + 2'd1))); // R4

    AST_BURST_KEEP_DIR: assert property (@(posedge clk) disable iff (!rst_n)
        (!cke_n && !zz && adv_ld) |=> (state_q == $past(state_q))); // R4

endmodule

bind zbt_sram_core zbt_sram_checker #(.AW(AW)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .cke_n   (cke_n),
    .zz      (zz),
    .adv_ld  (adv_ld),
    .sel     (sel),
    .dq_oe   (dq_oe),
    .wr_en   (wr_en),
    .state_q (state_q),
    .addr_q  (addr_q)
);

// File: tb/tb_zbt_sram_core.sv
`timescale 1ns/1ps
module tb_zbt_sram_core;

    localparam int AW = 6;
    localparam int DEPTH = 1 << AW;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ce1_n = 1'b1, ce2_n = 1'b0, ce3 = 1'b1;
    logic        adv_ld = 1'b0, rw_n = 1'b1;
    logic [3:0]  bw_n = 4'hF;
    logic        oe_n = 1'b0, cke_n = 1'b0, zz = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [35:0] dq_i = '0;
    logic [35:0] dq_o;
    logic        dq_oe;

    int checks = 0;
    int bad = 0;
    bit done = 0;

    always #5 clk = ~clk;

    zbt_sram_core #(.AW(AW)) dut (
        .clk(clk), .rst_n(rst_n), .ce1_n(ce1_n), .ce2_n(ce2_n), .ce3(ce3),
        .adv_ld(adv_ld), .rw_n(rw_n), .bw_n(bw_n), .oe_n(oe_n),
        .cke_n(cke_n), .zz(zz), .addr(addr), .dq_i(dq_i),
        .dq_o(dq_o), .dq_oe(dq_oe)
    );

    // ---------------- behavioural reference ----------------
    int          m_mode;   // 0 none, 1 reading, 2 writing
    int          m_addr;
    logic [3:0]  m_pend;
    logic [35:0] m_mem [DEPTH];
    logic        exp_oe;
    logic [35:0] exp_dq;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_mode <= 0; m_addr <= 0; m_pend <= 4'h0;
        end else if (zz) begin
            m_mode <= 0; m_pend <= 4'h0;
        end else if (!cke_n) begin
            if (m_mode == 2) begin
                for (int k = 0; k < 4; k++)
                    if (m_pend[k]) m_mem[m_addr][k*9 +: 9] <= dq_i[k*9 +: 9];
            end
            if (!adv_ld) begin
                if (ce1_n || ce2_n || !ce3) begin
                    m_mode <= 0; m_pend <= 4'h0;
                end else begin
                    m_addr <= int'(addr);
                    m_mode <= rw_n ? 1 : 2;
                    m_pend <= rw_n ? 4'h0 : ~bw_n;
                end
            end else if (m_mode != 0) begin
                m_addr <= (m_addr / 4) * 4 + ((m_addr + 1) % 4);
                m_pend <= (m_mode == 2) ? ~bw_n : 4'h0;
            end
        end
    end

    always_comb begin
        exp_oe = (m_mode == 1) && !oe_n && !zz;
        exp_dq = exp_oe ? m_mem[m_addr] : 36'h0;
    end

    function automatic logic [35:0] pat(input int a);
        logic [8:0] v;
        v = 9'(a);
        return {v ^ 9'h1A5, v ^ 9'h0F0, v ^ 9'h033, v ^ 9'h14C};
    endfunction

    // ---------------- check helpers ----------------
    task automatic chk_val(input string tag, input logic [35:0] got, input logic [35:0] exp);
        checks++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic cyc(input string tag);
        @(posedge clk);
        @(negedge clk);
        checks++;
        if (dq_oe !== exp_oe || dq_o !== exp_dq) begin
            bad++;
            $display("FAIL %s: oe=%b dq=%h expected oe=%b dq=%h",
                     tag, dq_oe, dq_o, exp_oe, exp_dq);
        end
    endtask

    task automatic ld(input int a, input logic rd, input logic [3:0] bw, input logic [35:0] d, input string tag);
        ce1_n = 0; ce2_n = 0; ce3 = 1; adv_ld = 0; rw_n = rd; bw_n = bw;
        addr = AW'(a); dq_i = d;
        cyc(tag);
    endtask

    task automatic cont(input logic [3:0] bw, input logic [35:0] d, input string tag);
        adv_ld = 1; rw_n = ~rw_n; bw_n = bw; dq_i = d; ce1_n = 1;
        cyc(tag);
    endtask

    task automatic desel(input int kind, input logic [35:0] d, input string tag);
        adv_ld = 0; rw_n = 1; dq_i = d;
        ce1_n = (kind == 0); ce2_n = (kind == 1); ce3 = (kind != 2);
        cyc(tag);
    endtask

    // ---------------- watchdog ----------------
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            bad++;
            $display("FAIL R1: watchdog expired, got hang expected completion");
            $display("  test done: total=%0d bad=%0d", checks, bad);
            $finish;
        end
    end

    // ---------------- scenarios ----------------
    initial begin
        for (int i = 0; i < DEPTH; i++) m_mem[i] = 36'h0;
        repeat (3) @(negedge clk);
        chk_val("R1 reset drive", {35'h0, dq_oe}, 36'h0);
        chk_val("R1 reset data", dq_o, 36'h0);
        rst_n = 1;
        cyc("R1 idle after reset");

        // fill: write bursts of four covering the array
        for (int b = 0; b < DEPTH / 4; b++) begin
            ld(b * 4, 1'b0, 4'h0, (b == 0) ? 36'h0 : pat(b * 4 - 1), "R5 fill load");
            for (int j = 1; j < 4; j++)
                cont(4'h0, pat(b * 4 + j - 1), "R5 fill cont");
        end
        desel(0, pat(DEPTH - 1), "R2 desel ce1");

        // read burst with wrap from 6
        ld(6, 1'b1, 4'hF, 36'h0, "R3 read load");
        chk_val("R3 read data", dq_o, pat(6));
        cont(4'hF, 36'h0, "R4 cont");
        chk_val("R4 step", dq_o, pat(7));
        cont(4'hF, 36'h0, "R4 cont");
        chk_val("R4 wrap low", dq_o, pat(4));
        cont(4'hF, 36'h0, "R4 cont");
        chk_val("R4 step", dq_o, pat(5));
        cont(4'hF, 36'h0, "R4 cont");
        chk_val("R4 back to start", dq_o, pat(6));

        // byte lanes + zero turnaround read
        ld(9, 1'b0, 4'b1010, 36'h0, "R8 write no drive");
        ld(9, 1'b1, 4'hF, 36'hF_FFFF_FFFF, "R11 read on data edge");
        chk_val("R5 lane merge", dq_o,
                {pat(9)[35:27], 9'h1FF, pat(9)[17:9], 9'h1FF});

        // write abort, counter still moves
        ld(12, 1'b0, 4'hF, 36'h0, "R6 abort load");
        cont(4'hF, 36'h1_2345_6789, "R6 abort cont");
        cont(4'h0, 36'h2_2222_2222, "R6 cont write");
        ld(12, 1'b1, 4'hF, 36'h3_3333_3333, "R6 read back");
        chk_val("R6 untouched", dq_o, pat(12));
        cont(4'hF, 36'h0, "R6 read");
        chk_val("R6 untouched", dq_o, pat(13));
        cont(4'hF, 36'h0, "R6 read");
        chk_val("R6 written after abort", dq_o, 36'h3_3333_3333);

        // dummy read
        oe_n = 1;
        ld(20, 1'b1, 4'hF, 36'h0, "R7 dummy");
        chk_val("R7 no drive", {35'h0, dq_oe}, 36'h0);
        cont(4'hF, 36'h0, "R7 dummy cont");
        oe_n = 0;
        cont(4'hF, 36'h0, "R7 advanced");
        chk_val("R7 advanced", dq_o, pat(22));

        // write with oe low
        ld(16, 1'b0, 4'h0, 36'h0, "R8 write oe low");
        chk_val("R8 bus off", {35'h0, dq_oe}, 36'h0);
        cont(4'h0, 36'h4_4444_4444, "R8 write cont");
        desel(1, 36'h5_5555_5555, "R2 desel ce2");

        // stall during read
        ld(24, 1'b1, 4'hF, 36'h0, "R9 read");
        cke_n = 1;
        cont(4'h0, 36'h0, "R9 stall read");
        chk_val("R9 read held", dq_o, pat(24));
        cont(4'h0, 36'h0, "R9 stall read");
        cke_n = 0;
        cont(4'hF, 36'h0, "R9 resume");
        chk_val("R9 resume next", dq_o, pat(25));

        // stall during pending write
        ld(30, 1'b0, 4'h0, 36'h0, "R9 write");
        cke_n = 1;
        cont(4'h0, 36'h6_6666_6666, "R9 stall write");
        cke_n = 0;
        ld(30, 1'b1, 4'hF, 36'h7_7777_7777, "R9 data after stall");
        chk_val("R9 stalled write data", dq_o, 36'h7_7777_7777);

        // deselect variants and continue while deselected
        desel(2, 36'h0, "R2 desel ce3");
        rw_n = 0;
        adv_ld = 1; ce1_n = 0; ce2_n = 0; ce3 = 1; rw_n = 1;
        cyc("R2 continue deselect");
        chk_val("R2 stays off", {35'h0, dq_oe}, 36'h0);
        cyc("R2 continue deselect");

        // sleep during read and pending write
        ld(32, 1'b1, 4'hF, 36'h0, "R10 read");
        zz = 1;
        #1;
        chk_val("R10 immediate off", {35'h0, dq_oe}, 36'h0);
        cyc("R10 sleep");
        zz = 0;
        cont(4'hF, 36'h0, "R10 stays deselected");
        ld(40, 1'b0, 4'h0, 36'h0, "R10 write");
        zz = 1;
        cont(4'h0, 36'h8_8888_8888, "R10 write dropped");
        zz = 0;
        ld(40, 1'b1, 4'hF, 36'h0, "R10 read back");
        chk_val("R10 no write", dq_o, pat(40));

        // read then write then read, no gaps
        ld(44, 1'b1, 4'hF, 36'h0, "R11 read");
        ld(44, 1'b0, 4'h0, 36'h0, "R11 write after read");
        ld(44, 1'b1, 4'hF, 36'h9_9999_9999, "R11 read after write");
        chk_val("R11 new data", dq_o, 36'h9_9999_9999);
        desel(0, 36'h0, "R2 final desel");

        done = 1;
        $display("  test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end

endmodule